// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel NOR flash. After software has issued a program or erase command sequence, it hands the poller three things: an address inside the sector being worked on, the data word it expects to end up there, and a poll budget. The poller then reads status words over a simple request/acknowledge read port until it can tell that the embedded operation has finished. No ready/busy pin is needed. It ends with a one-cycle `done` pulse and a two-bit result code.

There are two ways to decide that the operation is complete. In data mode the poller compares the polarity bit (bit 7) of each status read with bit 7 of the expected word. While the operation runs, the flash returns that bit inverted. In toggle mode the poller compares the toggle bit (bit 6) across two reads in a row. While the operation runs, that bit flips on every read. In toggle mode, if bit 6 holds still while bit 2 changes between the two reads, the address lies in an erase-suspended sector.

When a read that shows the operation still running also has the overtime bit (bit 5) set, the poller makes exactly one confirming read. It reports success only if that read shows completion. If completion never appears, the poll budget ends the wait with a timeout.

Top module: `fpoll_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy`, `done` and `rd_req` are 0.
- R2: A `start` pulse while idle launches reads at the address given with it. `rd_req` stays high with `rd_addr` stable until `rd_ack`. After each accepted read, `rd_req` is low for at least one cycle.
- R3: In data mode (`mode`=0), the first read whose bit 7 equals bit 7 of `exp_data` ends the wait with result 0 (success).
- R4: In toggle mode (`mode`=1), two reads in a row with equal bit 6 and equal bit 2 end the wait with result 0. The first read never gives a verdict.
- R5: In toggle mode, two reads in a row with equal bit 6 but different bit 2 end the wait with result 3 (suspended sector).
- R6: A read that shows the operation still running and has bit 5 set causes exactly one more read, even when the poll budget is used up. That read gives result 0 if it shows completion, result 3 if it shows a suspended sector, and result 2 (failure) otherwise.
- R7: A read that shows the operation still running, with bit 5 clear, gives result 1 (timeout) once the number of reads made reaches `limit`. A `limit` of 0 behaves as 1.
- R8: `done` is high for exactly one cycle, in the cycle after the one that follows the final acknowledged read. `busy` is low in that cycle. `result` then holds until the next start.
- R9: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (taken only when idle) |
| mode | input | 1 | 0 = data polling, 1 = toggle polling |
| addr | input | AW | Address inside the sector under operation |
| exp_data | input | DW | Word being programmed (bit 7 used) |
| limit | input | CW | Poll budget in reads |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data | input | DW | Read data; status in bits 7..0 |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 timeout, 2 failure, 3 suspended sector |

## Verification
Each acknowledged read is captured at the clock edge where `rd_ack` is seen high. The verdict is formed in the following cycle, so `done` rises one edge later, and the next request can follow no sooner than that. The responder stamps the cycle number of the final acknowledged read. The bench then requires `done` in exactly the next cycle and low again one cycle after. It compares the result code and the number of reads served with a prediction built from the sequence of status words it handed out. All sampling happens on the falling clock edge, away from the edge where the engine registers data.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    typedef enum logic {
        PM_DATA   = 1'b0,
        PM_TOGGLE = 1'b1
    } poll_mode_e;

    typedef enum logic [1:0] {
        RS_OK      = 2'd0,
        RS_TIMEOUT = 2'd1,
        RS_FAIL    = 2'd2,
        RS_SUSPEND = 2'd3
    } poll_res_e;

    typedef enum logic [2:0] {
        VD_NEED_MORE,
        VD_COMPLETE,
        VD_RUNNING,
        VD_RUN_OVERTIME,
        VD_SUSPENDED
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_JUDGE
    } eng_state_e;

    localparam int POS_POLARITY = 7;
    localparam int POS_TOGGLE   = 6;
    localparam int POS_OVERTIME = 5;
    localparam int POS_SUSP     = 2;

    typedef struct packed {
        logic polarity;
        logic toggle;
        logic overtime;
        logic susp;
    } stat_bits_t;

    function automatic stat_bits_t pick_bits(input logic [7:0] lane);
        stat_bits_t s;
        s.polarity = lane[POS_POLARITY];
        s.toggle   = lane[POS_TOGGLE];
        s.overtime = lane[POS_OVERTIME];
        s.susp     = lane[POS_SUSP];
        return s;
    endfunction

endpackage

// File: rtl/fpoll_judge.sv
module fpoll_judge
    import fpoll_pkg::*;
(
    input  poll_mode_e mode,
    input  logic       exp_pol,
    input  stat_bits_t cur,
    input  stat_bits_t prev,
    input  logic       have_prev,
    output verdict_e   verdict
);
    always_comb begin
        if (mode == PM_DATA) begin
            if (cur.polarity == exp_pol)
                verdict = VD_COMPLETE;
            else if (cur.overtime)
                verdict = VD_RUN_OVERTIME;
            else
                verdict = VD_RUNNING;
        end else begin
            if (!have_prev)
                verdict = VD_NEED_MORE;
            else if (cur.toggle == prev.toggle)
                verdict = (cur.susp != prev.susp) ? VD_SUSPENDED : VD_COMPLETE;
            else if (cur.overtime)
                verdict = VD_RUN_OVERTIME;
            else
                verdict = VD_RUNNING;
        end
    end
endmodule

// File: rtl/fpoll_counter.sv
module fpoll_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] lim,
    output logic          hit
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign hit = (cnt >= lim);

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R7
endmodule

// File: rtl/fpoll_engine.sv
module fpoll_engine
    import fpoll_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] exp_data,
    input  logic [CW-1:0] limit,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result
);
    localparam int LANE_W = (DW < 8) ? DW : 8;

    eng_state_e    state;
    logic [AW-1:0] addr_q;
    logic          exp_pol_q;
    poll_mode_e    mode_q;
    logic [CW-1:0] lim_q;
    stat_bits_t    cur_q, prev_q;
    logic          got_one, have_prev, rechk;
    poll_res_e     res_q;
    verdict_e      verdict;
    logic          lim_hit;
    logic [7:0]    lane;

    generate
        if (LANE_W == 8) begin : g_full_lane
            assign lane = rd_data[7:0];
        end else begin : g_short_lane
            assign lane = {{(8-LANE_W){1'b0}}, rd_data[LANE_W-1:0]};
        end
    endgenerate

    fpoll_judge u_judge (
        .mode      (mode_q),
        .exp_pol   (exp_pol_q),
        .cur       (cur_q),
        .prev      (prev_q),
        .have_prev (have_prev),
        .verdict   (verdict)
    );

    fpoll_counter #(.CW(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (state == ST_IDLE && start),
        .inc (state == ST_READ && rd_ack),
        .lim (lim_q),
        .hit (lim_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            exp_pol_q <= 1'b0;
            mode_q    <= PM_DATA;
            lim_q     <= '0;
            cur_q     <= '0;
            prev_q    <= '0;
            got_one   <= 1'b0;
            have_prev <= 1'b0;
            rechk     <= 1'b0;
            res_q     <= RS_OK;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q    <= addr;
                        exp_pol_q <= exp_data[POS_POLARITY];
                        mode_q    <= poll_mode_e'(mode);
                        lim_q     <= limit;
                        got_one   <= 1'b0;
                        have_prev <= 1'b0;
                        rechk     <= 1'b0;
                        state     <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (rd_ack) begin
                        cur_q     <= pick_bits(lane);
                        prev_q    <= cur_q;
                        have_prev <= got_one;
                        got_one   <= 1'b1;
                        state     <= ST_JUDGE;
                    end
                end
                ST_JUDGE: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                    case (verdict)
                        VD_COMPLETE:  res_q <= RS_OK;
                        VD_SUSPENDED: res_q <= RS_SUSPEND;
                        VD_NEED_MORE: begin
                            state <= ST_READ;
                            done  <= 1'b0;
                        end
                        VD_RUN_OVERTIME: begin
                            if (rechk) begin
                                res_q <= RS_FAIL;
                            end else begin
                                rechk <= 1'b1;
                                state <= ST_READ;
                                done  <= 1'b0;
                            end
                        end
                        default: begin
                            if (rechk) begin
                                res_q <= RS_FAIL;
                            end else if (lim_hit) begin
                                res_q <= RS_TIMEOUT;
                            end else begin
                                state <= ST_READ;
                                done  <= 1'b0;
                            end
                        end
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_req  = (state == ST_READ);
    assign rd_addr = addr_q;
    assign busy    = (state != ST_IDLE);
    assign result  = res_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R2
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack) |=> !rd_req); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result)); // R8
    AST_TIMEOUT_BUDGET: assert property (@(posedge clk) disable iff (rst)
        (done && result == RS_TIMEOUT) |-> lim_hit); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_req); // R9
endmodule

// File: tb/sim_fpoll_engine.sv
module sim_fpoll_engine;
    localparam int AW = 21;
    localparam int DW = 16;
    localparam int CW = 10;

    typedef struct {
        bit        mode;
        bit [15:0] exp;
        int        busy_reads;
        bit        err_en;
        int        err_at;
        bit        susp;
        int        limit;
    } scen_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] exp_data = '0;
    logic [CW-1:0] limit = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          busy, done;
    logic [1:0]    result;

    int total = 0, bad = 0, cyc = 0;
    int n_reads = 0, ack_cyc = 0, dly = 0;
    bit addr_bad = 0, gap_bad = 0, finished = 0;
    scen_t cur_s;
    logic [AW-1:0] cur_addr = '0;

    fpoll_engine #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .addr(addr),
        .exp_data(exp_data), .limit(limit), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done), .result(result)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [15:0] word(input scen_t s, input int i);
        logic [15:0] w = '0;
        if (s.susp) begin
            w[7] = ~s.exp[7];
            w[2] = i[0];
            return w;
        end
        if (i >= s.busy_reads) return s.exp;
        w[7] = ~s.exp[7];
        w[6] = i[0];
        w[5] = s.err_en && (i >= s.err_at);
        return w;
    endfunction

    // verdict codes: 0 more, 1 complete, 2 running, 3 overtime, 4 suspended
    task automatic predict(input scen_t s, output int res, output int nrd);
        logic [15:0] p = '0;
        bit rechk = 0;
        res = 0;
        nrd = 0;
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] w = word(s, i);
            int v;
            nrd = i + 1;
            if (!s.mode)
                v = (w[7] == s.exp[7]) ? 1 : (w[5] ? 3 : 2);
            else if (i == 0)
                v = 0;
            else if (w[6] == p[6])
                v = (w[2] != p[2]) ? 4 : 1;
            else
                v = w[5] ? 3 : 2;
            p = w;
            if (v == 1) begin res = 0; return; end
            if (v == 4) begin res = 3; return; end
            if (v == 3) begin
                if (rechk) begin res = 2; return; end
                rechk = 1;
            end else if (v == 2) begin
                if (rechk) begin res = 2; return; end
                if (nrd >= s.limit) begin res = 1; return; end
            end
        end
    endtask

    function automatic string tag_of(input int res, input bit md);
        case (res)
            0: return md ? "R4" : "R3";
            1: return "R7";
            2: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
        end
    endtask

    // flash responder
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack = 1'b0;
            n_reads++;
            ack_cyc = cyc;
            if (rd_req) gap_bad = 1;
        end else if (rd_req) begin
            if (dly > 0) dly--;
            else begin
                if (rd_addr != cur_addr) addr_bad = 1;
                rd_data = word(cur_s, n_reads);
                rd_ack = 1'b1;
                dly = $urandom % 3;
            end
        end
    end

    task automatic run_scen(input scen_t s, input bit poke);
        int eres, enrd, wait_n;
        predict(s, eres, enrd);
        @(negedge clk);
        cur_s = s;
        n_reads = 0;
        addr_bad = 0;
        gap_bad = 0;
        cur_addr = AW'($urandom);
        addr = cur_addr;
        mode = s.mode;
        exp_data = s.exp;
        limit = CW'(s.limit);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            if (busy) begin
                addr = ~cur_addr;
                mode = ~s.mode;
                limit = '0;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        wait_n = 0;
        while (!done && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        check(done, "R8", "done seen", done, 1);
        check(result == 2'(eres), tag_of(eres, s.mode), "result", result, eres);
        check(n_reads == enrd, (eres == 2) ? "R6" : "R7", "reads", n_reads, enrd);
        check(cyc == ack_cyc + 1, "R8", "done cycle", cyc, ack_cyc + 1);
        check(!busy, "R8", "busy at done", busy, 0);
        check(!addr_bad, poke ? "R9" : "R2", "read address", addr_bad, 0);
        check(!gap_bad, "R2", "gap after ack", gap_bad, 0);
        @(negedge clk);
        check(!done, "R8", "done width", done, 0);
        repeat (3) @(negedge clk);
        check(result == 2'(eres) && !rd_req, "R8", "result held", result, eres);
    endtask

    function automatic scen_t mk(bit md, int b, bit ee, int ea, bit su, int lm);
        scen_t s;
        s.mode = md; s.exp = 16'($urandom); s.busy_reads = b;
        s.err_en = ee; s.err_at = ea; s.susp = su; s.limit = lm;
        return s;
    endfunction

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        check(!busy && !done && !rd_req, "R1", "reset outputs", {busy, done, rd_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !rd_req, "R1", "after reset", {busy, done, rd_req}, 0);
        run_scen(mk(0, 3, 0, 0, 0, 10), 0);  // R3
        run_scen(mk(0, 0, 0, 0, 0, 10), 0);  // R3 first read
        run_scen(mk(1, 4, 0, 0, 0, 20), 0);  // R4
        run_scen(mk(1, 0, 0, 0, 1, 20), 0);  // R5
        run_scen(mk(0, 20, 0, 0, 0, 5), 0);  // R7
        run_scen(mk(0, 5, 0, 0, 0, 0), 0);   // R7 zero budget
        run_scen(mk(1, 30, 0, 0, 0, 0), 0);  // R7 toggle
        run_scen(mk(0, 3, 1, 2, 0, 10), 0);  // R6 recheck ok
        run_scen(mk(0, 10, 1, 1, 0, 10), 0); // R6 recheck fail
        run_scen(mk(0, 50, 1, 1, 0, 2), 0);  // R6 beyond budget
        run_scen(mk(1, 9, 1, 3, 0, 20), 0);  // R6 toggle
        run_scen(mk(0, 6, 0, 0, 0, 12), 1);  // R9
        for (int k = 0; k < 24; k++) begin
            bit md = 1'($urandom);
            run_scen(mk(md, $urandom % 12, ($urandom % 4) == 0, $urandom % 8,
                        md && (($urandom % 6) == 0), $urandom % 16), k[0]);
        end
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule